// File: doc/BRIEF.md
# Configurable Watchdog Timer with Prescaler

This block is a watchdog for a microcontroller. A prescaler divides either the system clock or a slow-oscillator enable pulse. Each prescaler period decrements a 14-bit down-counter, and the counter reloads from one of four programmed values. If software does not refresh the counter in time, it reaches its underflow point. The block then issues either a one-cycle interrupt request or a one-cycle reset request, depending on a static action-select input.

Software writes through a small register port. Address 0 is the refresh (kick) register, and a refresh needs two writes in a row: 00h and then FFh. Address 1 is the start register. A static configuration input decides whether counting begins directly after reset or waits for a write to the start register. Two low-power inputs, wait and stop, halt counting when the source is the system clock. When the source is the slow oscillator, counting continues in both modes. The current count is brought out so that it can be observed.

Top module: `watchdog_unit`

## Requirements
- R1: During and right after a synchronous reset, `count_o` equals the reload value selected by `ufl_sel`, and `irq_o` and `rst_req_o` are 0.
- R2: `ufl_sel` selects the reload value: 00b gives 03FFh, 01b gives 0FFFh, 10b gives 1FFFh and 11b gives 3FFFh.
- R3: The counter decrements by one per prescaler period. At the prescaler period that finds the count at 1, the counter reloads instead and an underflow occurs, so two underflows lie n × m clock cycles apart (n is the prescaler ratio, m the reload value).
- R4: A write of 00h to address 0, followed by a write of FFh to address 0 as the next write there, reloads the counter at the clock edge of the FFh write. A refresh in the same cycle as an underflow point takes priority and suppresses the underflow.
- R5: A second write to address 0 of any value other than FFh (or 00h, which re-arms) disarms the sequence without a reload. An FFh write that does not directly follow a 00h write has no effect on the count.
- R6: With `act_irq`=1, an underflow sets `irq_o` for exactly one cycle, at the same edge as the reload. With `act_irq`=0, it sets `rst_req_o` for one cycle instead, and the other output stays 0.
- R7: With `hold_cfg`=0, counting starts directly after reset. With `hold_cfg`=1, the counter and the prescaler stay stopped until any write to address 1. Writes to address 0 while stopped are ignored and do not arm the refresh sequence.
- R8: With `src_sel` other than 11b, a high `sleep_wait` or `sleep_stop` freezes the count. With `src_sel`=11b, counting continues in those modes.
- R9: `src_sel` 00b, 01b and 10b divide the system clock by 2, 16 and 128. 11b divides `lso_tick` pulses by 16. The prescaler is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_cfg | input | 1 | 1: wait for start write after reset; 0: run at once |
| src_sel | input | 2 | Prescaler source and ratio select |
| ufl_sel | input | 2 | Reload value select |
| act_irq | input | 1 | Underflow action: 1 interrupt, 0 reset request |
| lso_tick | input | 1 | Single-cycle slow-oscillator enable pulse |
| sleep_wait | input | 1 | Wait low-power mode active |
| sleep_stop | input | 1 | Stop low-power mode active |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: refresh register, 1: start register |
| wr_data | input | 8 | Write data |
| count_o | output | 14 | Current count |
| irq_o | output | 1 | One-cycle interrupt request |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Faults in the prescaler show up as a wrong spacing between changes of `count_o`, and the error is visible within one prescaler period of 2 to 128 cycles. A wrong reload value or a wrong underflow point shows up at reset, at the first refresh, or as a wrong interval between request pulses. A stale or wrongly set arm bit in the refresh tracker shows up on the next FFh write, which reloads when it should not or fails to reload when it should. A run flag that does not hold shows up as a count that moves while the timer should still be waiting for its start write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 14;
  localparam int RATIO_W = 8;

  function automatic logic [CNT_W-1:0] reload_of(input logic [1:0] sel);
    case (sel)
      2'b00:   reload_of = CNT_W'(14'h03FF);
      2'b01:   reload_of = CNT_W'(14'h0FFF);
      2'b10:   reload_of = CNT_W'(14'h1FFF);
      default: reload_of = CNT_W'(14'h3FFF);
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [1:0] sel);
    case (sel)
      2'b00:   ratio_of = RATIO_W'(2);
      2'b01:   ratio_of = RATIO_W'(16);
      2'b10:   ratio_of = RATIO_W'(128);
      default: ratio_of = RATIO_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [PRE_W-1:0] ratio_m1,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  assign tick = advance && (pre_q >= ratio_m1);

  always_ff @(posedge clk) begin
    if (rst)          pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else if (advance) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_kick_seq.sv
module wdt_kick_seq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [DATA_W-1:0] data,
  output logic              kick
);
  localparam logic [DATA_W-1:0] ARM_CODE  = '0;
  localparam logic [DATA_W-1:0] FIRE_CODE = '1;

  logic armed_q;

  assign kick = strobe && armed_q && (data == FIRE_CODE);

  always_ff @(posedge clk) begin
    if (rst)         armed_q <= 1'b0;
    else if (strobe) armed_q <= (data == ARM_CODE);
  end
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             uflow
);
  assign uflow = tick && !kick && (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || kick || uflow) count <= reload;
    else if (tick)            count <= count - 1'b1;
  end
endmodule

// File: rtl/watchdog_unit.sv
module watchdog_unit
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_cfg,
  input  logic [1:0]        src_sel,
  input  logic [1:0]        ufl_sel,
  input  logic              act_irq,
  input  logic              lso_tick,
  input  logic              sleep_wait,
  input  logic              sleep_stop,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam logic [1:0] SRC_SLOW = 2'b11;

  logic running_q;
  logic slow_src, halted, advance, tick, kick, uflow, kick_wr;
  logic [RATIO_W-1:0] ratio;
  logic [PRE_W-1:0]   ratio_m1;

  assign slow_src = (src_sel == SRC_SLOW);
  assign halted   = !slow_src && (sleep_wait || sleep_stop);
  assign advance  = running_q && !halted && (slow_src ? lso_tick : 1'b1);
  assign ratio    = ratio_of(src_sel);
  assign ratio_m1 = PRE_W'(ratio - 1'b1);
  assign kick_wr  = wr_en && !wr_addr && running_q;

  always_ff @(posedge clk) begin
    if (rst)                 running_q <= !hold_cfg;
    else if (wr_en && wr_addr) running_q <= 1'b1;
  end

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .advance(advance), .ratio_m1(ratio_m1), .tick(tick)
  );

  wdt_kick_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .strobe(kick_wr), .data(wr_data), .kick(kick)
  );

  wdt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .kick(kick),
    .reload(reload_of(ufl_sel)), .count(count_o), .uflow(uflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o     <= uflow && act_irq;
      rst_req_o <= uflow && !act_irq;
    end
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [1:0]       src_sel,
  input logic [1:0]       ufl_sel,
  input logic             act_irq,
  input logic             sleep_wait,
  input logic             sleep_stop,
  input logic             wr_en,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             rst_req_o
);
  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (count_o != $past(count_o)) |->
      (count_o == $past(count_o) - 14'd1 || count_o == reload_of($past(ufl_sel))));

  assert_uflow_point_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_o || rst_req_o) |-> ($past(count_o) == 14'd1));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  assert_action_irq_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(act_irq));

  assert_action_rst_R6: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> !$past(act_irq));

  assert_sleep_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && src_sel != 2'b11 && (sleep_wait || sleep_stop) && !wr_en)
      |-> $stable(count_o));
endmodule

bind watchdog_unit wdt_checker u_chk (
  .clk(clk), .rst(rst), .src_sel(src_sel), .ufl_sel(ufl_sel),
  .act_irq(act_irq), .sleep_wait(sleep_wait), .sleep_stop(sleep_stop),
  .wr_en(wr_en), .count_o(count_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
);

// File: tb/tb_watchdog_unit.sv
`timescale 1ns/1ps
module tb_watchdog_unit;
  logic clk = 0, rst = 1, hold_cfg = 0, act_irq = 1, lso_tick = 0;
  logic [1:0] src_sel = 0, ufl_sel = 0;
  logic sleep_wait = 0, sleep_stop = 0, wr_en = 0, wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [13:0] count_o;
  logic irq_o, rst_req_o;
  logic lso_on = 0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  watchdog_unit dut (.*);

  int lso_div = 0;
  always @(negedge clk) begin
    lso_tick <= 1'b0;
    if (lso_on) begin
      lso_div <= (lso_div == 2) ? 0 : lso_div + 1;
      if (lso_div == 2) lso_tick <= 1'b1;
    end
  end

  function automatic int exp_reload(input logic [1:0] s);
    case (s) 2'b00: return 'h3FF; 2'b01: return 'hFFF; 2'b10: return 'h1FFF; default: return 'h3FFF; endcase
  endfunction
  function automatic int exp_ratio(input logic [1:0] s);
    case (s) 2'b00: return 2; 2'b01: return 16; 2'b10: return 128; default: return 16; endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s, input logic [1:0] u, input logic h);
    @(negedge clk);
    src_sel = s; ufl_sel = u; hold_cfg = h; rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_len(output int n);
    logic [13:0] prev;
    prev = count_o; n = 0;
    while (count_o == prev && n < 2000) begin @(negedge clk); n++; end
    prev = count_o; n = 0;
    while (count_o == prev && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic armed;
    void'($urandom(32'd20240607));

    // R1 / R2: reset state and reload encodings
    for (int u = 0; u < 4; u++) begin
      do_reset(2'b00, u[1:0], 1'b0);
      check("R2", "reload after reset", count_o, exp_reload(u[1:0]));
    end
    @(negedge clk); rst = 1; @(negedge clk);
    check("R1", "count in reset", count_o, exp_reload(ufl_sel));
    check("R1", "irq in reset", irq_o, 0);
    check("R1", "rst_req in reset", rst_req_o, 0);

    // R3 / R6: div2, full underflow interval n*m and one-cycle pulse
    act_irq = 1;
    do_reset(2'b00, 2'b00, 1'b0);
    n = 0;
    while (!irq_o && n < 5000) begin @(negedge clk); n++; end
    check("R6", "irq seen", irq_o, 1);
    check("R6", "rst_req quiet with irq action", rst_req_o, 0);
    @(negedge clk);
    check("R6", "irq one cycle", irq_o, 0);
    n = 1;
    while (!irq_o && n < 5000) begin @(negedge clk); n++; end
    check("R3", "underflow interval div2", n, 2 * exp_reload(2'b00));

    // R6: reset-request action
    act_irq = 0;
    do_reset(2'b00, 2'b00, 1'b0);
    n = 0;
    while (!rst_req_o && !irq_o && n < 5000) begin @(negedge clk); n++; end
    check("R6", "rst_req seen", rst_req_o, 1);
    check("R6", "irq quiet with reset action", irq_o, 0);
    @(negedge clk);
    check("R6", "rst_req one cycle", rst_req_o, 0);
    act_irq = 1;

    // R9: prescaler ratios
    for (int s = 0; s < 3; s++) begin
      do_reset(s[1:0], 2'b00, 1'b0);
      step_len(n);
      check("R9", "count step on clock source", n, exp_ratio(s[1:0]));
    end
    lso_on = 1;
    do_reset(2'b11, 2'b00, 1'b0);
    step_len(n);
    check("R9", "count step on slow source", n, 16 * 3);

    // R8: slow source keeps counting in stop mode
    sleep_stop = 1;
    step_len(n);
    check("R8", "slow source counts in stop", n, 16 * 3);
    sleep_stop = 0;
    lso_on = 0;

    // R8: clock source frozen in wait mode
    do_reset(2'b00, 2'b00, 1'b0);
    idle(10);
    sleep_wait = 1;
    idle(1);
    begin
      logic [13:0] held;
      held = count_o;
      idle(100);
      check("R8", "frozen in wait", count_o, held);
    end
    sleep_wait = 0;

    // R4 / R5: directed refresh sequences
    do_reset(2'b00, 2'b01, 1'b0);
    idle(20);
    wr(1'b0, 8'h00); wr(1'b0, 8'hFF);
    check("R4", "00h then FFh reloads", count_o, exp_reload(2'b01));
    idle(20);
    wr(1'b0, 8'h00); wr(1'b0, 8'h5A); wr(1'b0, 8'hFF);
    check("R5", "disarmed sequence no reload", count_o != exp_reload(2'b01), 1);
    idle(10);
    wr(1'b0, 8'hFF);
    check("R5", "lone FFh no reload", count_o != exp_reload(2'b01), 1);

    // R4 / R5: random refresh traffic against a bench arm model
    armed = 0;
    for (int i = 0; i < 60; i++) begin
      int r;
      logic [7:0] d;
      logic exp_kick;
      r = $urandom % 3;
      d = (r == 0) ? 8'h00 : (r == 1) ? 8'hFF : 8'(1 + ($urandom % 254));
      exp_kick = armed && (d == 8'hFF);
      armed = (d == 8'h00);
      wr(1'b0, d);
      check(exp_kick ? "R4" : "R5", "random refresh reload",
            count_o == exp_reload(2'b01), exp_kick);
      idle(4 + $urandom % 5);
    end

    // R7: hold after reset, ignored refresh while stopped, start write
    do_reset(2'b00, 2'b00, 1'b1);
    idle(300);
    check("R7", "held count", count_o, exp_reload(2'b00));
    check("R7", "held no irq", irq_o, 0);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h01);
    idle(20);
    check("R7", "counting after start", count_o < exp_reload(2'b00), 1);
    wr(1'b0, 8'hFF);
    check("R7", "refresh write while stopped ignored", count_o != exp_reload(2'b00), 1);
    do_reset(2'b00, 2'b00, 1'b0);
    idle(20);
    check("R7", "auto start", count_o < exp_reload(2'b00), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule